// File: doc/BRIEF.md
# Register Window Occupancy Controller

This block holds the bookkeeping state for a processor whose integer registers are organised as a ring of `NWIN` overlapping windows. It keeps five values: the current window pointer, the number of windows that may still be saved, the number that may be restored, the number owned by another context, and the number of clean windows.

A privileged write port loads any one of the five values. The value written is the XOR of two operands, or of one operand and a zero-extended immediate. Each write is range checked before it is allowed to land. Two event strobes report that a window was saved or restored, and these move the three coupled counters together. Whichever side is being drained takes from the other-context count first, and the clean count saturates at its limit. A trap-return input reloads the window pointer. All five values are presented on the outputs continuously, and two one-cycle error pulses report rejected writes and rejected events.

Top module: `win_occ_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the outputs read as follows. Window pointer 0, save count `NWIN-2`, restore count 0, other-context count 0, clean count `NWIN`, and both error outputs 0.
- R2: A write forms its value as `wr_opa ^ wr_opb`, or as `wr_opa ^ zero_extend(wr_imm)` when `wr_imm_sel` is 1. The value loads the register picked by `wr_sel` (0 pointer, 1 save, 2 restore, 3 other-context, 4 clean) and is visible one cycle later. Selector codes 5 to 7 change nothing.
- R3: A written value above `NWIN-1` is rejected for the pointer and for the save, restore and other-context counts. A value above `NWIN` is rejected for the clean count. Range checks use the full operand width. A rejected write leaves every register unchanged and sets `err_range` for exactly the following cycle.
- R4: A save event adds one to the save count. If the other-context count is nonzero it loses one; otherwise the restore count loses one.
- R5: A restore event adds one to the restore count. If the other-context count is nonzero it loses one; otherwise the save count loses one. The clean count also gains one unless it already equals `NWIN`.
- R6: An event is dropped as a whole, with `err_event` set for the following cycle, in two cases. One is that it would take a count below zero. The other is that it would raise the save or restore count above `NWIN-1`.
- R7: In a cycle with a write to selector 0 to 4, the write is the only change made. Events and trap return in that cycle are ignored.
- R8: When both event strobes are high together, only the save event is applied.
- R9: A trap return loads `tr_cwp` into the window pointer when it is at most `NWIN-1`. Otherwise the pointer is kept and `err_range` is set for the following cycle. When no write blocks it, a trap return and an event in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Privileged write strobe |
| wr_sel | input | 3 | Target register code |
| wr_opa | input | DW | First write operand |
| wr_opb | input | DW | Second write operand |
| wr_imm | input | IW | Immediate operand, zero-extended |
| wr_imm_sel | input | 1 | 1 selects the immediate instead of `wr_opb` |
| ev_saved | input | 1 | Window-saved event |
| ev_restored | input | 1 | Window-restored event |
| tr_en | input | 1 | Trap-return load of the window pointer |
| tr_cwp | input | CW | Pointer value for trap return |
| cwp | output | CW | Current window pointer |
| cansave | output | CW | Save count |
| canrestore | output | CW | Restore count |
| otherwin | output | CW | Other-context count |
| cleanwin | output | CW | Clean-window count |
| err_range | output | 1 | Rejected write or trap-return value, one-cycle pulse |
| err_event | output | 1 | Rejected event, one-cycle pulse |

## Verification
The bench uses the defaults: `NWIN` = 8, a 4-bit counter width, 16-bit operands and a 13-bit immediate. With eight windows, the clean count can sit at 8 and show saturation while the other counters stop at 7, so both limits are reachable in a few writes. The 4-bit `tr_cwp` can carry 8 to 15, which exercises the trap-return range rejection. The 16-bit operands let a value with only high bits set show that range checks are not truncated to the counter width.

// File: rtl/wocc_pkg.sv
package wocc_pkg;
  localparam int NREG = 5;
  localparam logic [2:0] SEL_CWP        = 3'd0;
  localparam logic [2:0] SEL_CANSAVE    = 3'd1;
  localparam logic [2:0] SEL_CANRESTORE = 3'd2;
  localparam logic [2:0] SEL_OTHERWIN   = 3'd3;
  localparam logic [2:0] SEL_CLEANWIN   = 3'd4;
endpackage

// File: rtl/wocc_wr_decode.sv
// Forms the write value and range checks it per target register.
module wocc_wr_decode
  import wocc_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = 4,
  parameter int DW   = 16,
  parameter int IW   = 13
) (
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [DW-1:0]   wr_opa,
  input  logic [DW-1:0]   wr_opb,
  input  logic [IW-1:0]   wr_imm,
  input  logic            wr_imm_sel,
  output logic [NREG-1:0] ld,
  output logic [CW-1:0]   ld_val,
  output logic            wr_hit,
  output logic            wr_bad
);
  logic [DW-1:0]   src2;
  logic [DW-1:0]   val;
  logic [NREG-1:0] sel_hit;
  logic [NREG-1:0] legal;

  assign src2 = wr_imm_sel ? DW'(wr_imm) : wr_opb;
  assign val  = wr_opa ^ src2;

  // Range limit per register: clean count may reach NWIN, others NWIN-1.
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int LIM = (g == int'(SEL_CLEANWIN)) ? NWIN : NWIN - 1;
    assign sel_hit[g] = wr_en && (wr_sel == 3'(g));
    assign legal[g]   = (val <= DW'(LIM));
    assign ld[g]      = sel_hit[g] && legal[g];
  end

  assign wr_hit = |sel_hit;
  assign wr_bad = |(sel_hit & ~legal);
  assign ld_val = val[CW-1:0];
endmodule

// File: rtl/wocc_evt.sv
// Next counter values for a saved or restored window event.
module wocc_evt #(
  parameter int NWIN = 8,
  parameter int CW   = 4
) (
  input  logic          ev_saved,
  input  logic          ev_restored,
  input  logic          blk,
  input  logic [CW-1:0] cs,
  input  logic [CW-1:0] cr,
  input  logic [CW-1:0] ow,
  input  logic [CW-1:0] cw,
  output logic [CW-1:0] cs_d,
  output logic [CW-1:0] cr_d,
  output logic [CW-1:0] ow_d,
  output logic [CW-1:0] cw_d,
  output logic          upd,
  output logic          ev_err
);
  localparam logic [CW-1:0] TOP  = CW'(NWIN - 1);
  localparam logic [CW-1:0] FULL = CW'(NWIN);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] ZERO = '0;

  always_comb begin
    cs_d   = cs;
    cr_d   = cr;
    ow_d   = ow;
    cw_d   = cw;
    upd    = 1'b0;
    ev_err = 1'b0;
    if (!blk && ev_saved) begin
      if (cs == TOP || (ow == ZERO && cr == ZERO)) begin
        ev_err = 1'b1;
      end else begin
        upd  = 1'b1;
        cs_d = cs + ONE;
        if (ow != ZERO) ow_d = ow - ONE;
        else            cr_d = cr - ONE;
      end
    end else if (!blk && ev_restored) begin
      if (cr == TOP || (ow == ZERO && cs == ZERO)) begin
        ev_err = 1'b1;
      end else begin
        upd  = 1'b1;
        cr_d = cr + ONE;
        if (ow != ZERO) ow_d = ow - ONE;
        else            cs_d = cs - ONE;
        if (cw != FULL) cw_d = cw + ONE;
      end
    end
  end
endmodule

// File: rtl/win_occ_ctrl.sv
module win_occ_ctrl
  import wocc_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN + 1),
  parameter int DW   = 16,
  parameter int IW   = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_opa,
  input  logic [DW-1:0] wr_opb,
  input  logic [IW-1:0] wr_imm,
  input  logic          wr_imm_sel,
  input  logic          ev_saved,
  input  logic          ev_restored,
  input  logic          tr_en,
  input  logic [CW-1:0] tr_cwp,
  output logic [CW-1:0] cwp,
  output logic [CW-1:0] cansave,
  output logic [CW-1:0] canrestore,
  output logic [CW-1:0] otherwin,
  output logic [CW-1:0] cleanwin,
  output logic          err_range,
  output logic          err_event
);
  localparam logic [CW-1:0] TOP  = CW'(NWIN - 1);
  localparam logic [CW-1:0] FULL = CW'(NWIN);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0]   cwp_q, cs_q, cr_q, ow_q, cw_q;
  logic [CW-1:0]   cwp_d, cs_d, cr_d, ow_d, cw_d;
  logic            en_cwp, en_cs, en_cr, en_ow, en_cw;
  logic            err_r_q, err_e_q, err_r_d;
  logic [NREG-1:0] ld;
  logic [CW-1:0]   ld_val;
  logic            wr_hit, wr_bad;
  logic [CW-1:0]   e_cs, e_cr, e_ow, e_cw;
  logic            upd, ev_err;
  logic            tr_ok, tr_bad;

  wocc_wr_decode #(.NWIN(NWIN), .CW(CW), .DW(DW), .IW(IW)) u_dec (
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_opa(wr_opa), .wr_opb(wr_opb),
    .wr_imm(wr_imm), .wr_imm_sel(wr_imm_sel),
    .ld(ld), .ld_val(ld_val), .wr_hit(wr_hit), .wr_bad(wr_bad)
  );

  wocc_evt #(.NWIN(NWIN), .CW(CW)) u_evt (
    .ev_saved(ev_saved), .ev_restored(ev_restored), .blk(wr_hit),
    .cs(cs_q), .cr(cr_q), .ow(ow_q), .cw(cw_q),
    .cs_d(e_cs), .cr_d(e_cr), .ow_d(e_ow), .cw_d(e_cw),
    .upd(upd), .ev_err(ev_err)
  );

  // Trap return yields to any decoded write in the same cycle.
  assign tr_ok  = tr_en && !wr_hit && (tr_cwp <= TOP);
  assign tr_bad = tr_en && !wr_hit && (tr_cwp > TOP);

  // Next-state selection and clock enables.
  always_comb begin
    en_cwp  = ld[SEL_CWP] | tr_ok;
    en_cs   = ld[SEL_CANSAVE] | upd;
    en_cr   = ld[SEL_CANRESTORE] | upd;
    en_ow   = ld[SEL_OTHERWIN] | upd;
    en_cw   = ld[SEL_CLEANWIN] | upd;
    cwp_d   = ld[SEL_CWP]        ? ld_val : tr_cwp;
    cs_d    = ld[SEL_CANSAVE]    ? ld_val : e_cs;
    cr_d    = ld[SEL_CANRESTORE] ? ld_val : e_cr;
    ow_d    = ld[SEL_OTHERWIN]   ? ld_val : e_ow;
    cw_d    = ld[SEL_CLEANWIN]   ? ld_val : e_cw;
    err_r_d = wr_bad | tr_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q   <= '0;
      cs_q    <= CW'(NWIN - 2);
      cr_q    <= '0;
      ow_q    <= '0;
      cw_q    <= FULL;
      err_r_q <= 1'b0;
      err_e_q <= 1'b0;
    end else begin
      if (en_cwp) cwp_q <= cwp_d;
      if (en_cs)  cs_q  <= cs_d;
      if (en_cr)  cr_q  <= cr_d;
      if (en_ow)  ow_q  <= ow_d;
      if (en_cw)  cw_q  <= cw_d;
      err_r_q <= err_r_d;
      err_e_q <= ev_err;
    end
  end

  assign cwp        = cwp_q;
  assign cansave    = cs_q;
  assign canrestore = cr_q;
  assign otherwin   = ow_q;
  assign cleanwin   = cw_q;
  assign err_range  = err_r_q;
  assign err_event  = err_e_q;

  // Legal ranges always hold.
  a_r3_counts_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (cwp_q <= TOP) && (cs_q <= TOP) && (cr_q <= TOP) && (ow_q <= TOP));
  a_r5_clean_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cw_q <= FULL);
  // Save event applied: save count steps up.
  a_r4_saved_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_saved && !wr_hit && !ev_err) |=> (cs_q == $past(cs_q) + ONE));
  // Lone restore event applied: restore count steps up.
  a_r5_restored_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_restored && !ev_saved && !wr_hit && !ev_err) |=> (cr_q == $past(cr_q) + ONE));
  // Rejected write touches nothing and flags.
  a_r3_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> (err_range && $stable(cwp_q) && $stable(cs_q) && $stable(cr_q)
                && $stable(ow_q) && $stable(cw_q)));
  // Rejected event leaves the counters as they were.
  a_r6_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err && !wr_hit) |=> (err_event && $stable(cs_q) && $stable(cr_q)
                             && $stable(ow_q) && $stable(cw_q)));
  // Legal trap return lands in the pointer.
  a_r9_trap_load: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_en && !wr_hit && (tr_cwp <= TOP)) |=> (cwp_q == $past(tr_cwp)));
endmodule

// File: tb/sim_win_occ_ctrl.sv
`timescale 1ns/1ps
module sim_win_occ_ctrl;
  localparam int NWIN = 8;
  localparam int CW   = 4;
  localparam int DW   = 16;
  localparam int IW   = 13;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, wr_imm_sel, ev_saved, ev_restored, tr_en;
  logic [2:0]    wr_sel;
  logic [DW-1:0] wr_opa, wr_opb;
  logic [IW-1:0] wr_imm;
  logic [CW-1:0] tr_cwp;
  logic [CW-1:0] cwp, cansave, canrestore, otherwin, cleanwin;
  logic          err_range, err_event;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int m_cwp, m_cs, m_cr, m_ow, m_cw, m_er, m_ee;

  always #4 clk = ~clk;

  win_occ_ctrl #(.NWIN(NWIN), .CW(CW), .DW(DW), .IW(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_opa(wr_opa), .wr_opb(wr_opb), .wr_imm(wr_imm), .wr_imm_sel(wr_imm_sel),
    .ev_saved(ev_saved), .ev_restored(ev_restored), .tr_en(tr_en), .tr_cwp(tr_cwp),
    .cwp(cwp), .cansave(cansave), .canrestore(canrestore), .otherwin(otherwin),
    .cleanwin(cleanwin), .err_range(err_range), .err_event(err_event)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "cwp", int'(cwp), m_cwp);
    chk(req, "cansave", int'(cansave), m_cs);
    chk(req, "canrestore", int'(canrestore), m_cr);
    chk(req, "otherwin", int'(otherwin), m_ow);
    chk(req, "cleanwin", int'(cleanwin), m_cw);
    chk(req, "err_range", int'(err_range), m_er);
    chk(req, "err_event", int'(err_event), m_ee);
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_sel = 0; wr_opa = 0; wr_opb = 0; wr_imm = 0; wr_imm_sel = 0;
    ev_saved = 0; ev_restored = 0; tr_en = 0; tr_cwp = 0;
  endtask

  // One cycle of stimulus; the expected state is worked out from the requirements.
  task automatic step(input string req, input bit we, input int sel, input int a,
                      input int b, input int im, input bit isel, input bit es,
                      input bit er, input bit te, input int tv);
    int v;
    int lim;
    wr_en = we; wr_sel = 3'(sel); wr_opa = DW'(a); wr_opb = DW'(b);
    wr_imm = IW'(im); wr_imm_sel = isel; ev_saved = es; ev_restored = er;
    tr_en = te; tr_cwp = CW'(tv);
    m_er = 0; m_ee = 0;
    v = (a & 16'hFFFF) ^ (isel ? (im & 13'h1FFF) : (b & 16'hFFFF));
    if (we && sel <= 4) begin
      lim = (sel == 4) ? NWIN : NWIN - 1;
      if (v > lim) m_er = 1;
      else case (sel)
        0: m_cwp = v;
        1: m_cs = v;
        2: m_cr = v;
        3: m_ow = v;
        default: m_cw = v;
      endcase
    end else begin
      if (te) begin
        if (tv <= NWIN - 1) m_cwp = tv;
        else m_er = 1;
      end
      if (es) begin
        if (m_cs == NWIN - 1 || (m_ow == 0 && m_cr == 0)) m_ee = 1;
        else begin
          m_cs++;
          if (m_ow != 0) m_ow--; else m_cr--;
        end
      end else if (er) begin
        if (m_cr == NWIN - 1 || (m_ow == 0 && m_cs == 0)) m_ee = 1;
        else begin
          m_cr++;
          if (m_ow != 0) m_ow--; else m_cs--;
          if (m_cw < NWIN) m_cw++;
        end
      end
    end
    @(negedge clk);
    chk_all(req);
    idle_inputs();
  endtask

  task automatic t_reset();
    rst_n = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    m_cwp = 0; m_cs = NWIN - 2; m_cr = 0; m_ow = 0; m_cw = NWIN; m_er = 0; m_ee = 0;
    chk_all("R1");
    rst_n = 1;
    @(negedge clk);
    chk_all("R1");
  endtask

  task automatic t_write();
    step("R2", 1, 1, 5, 3, 0, 0, 0, 0, 0, 0);      // save count 6 from XOR
    step("R2", 1, 2, 1, 9, 3, 1, 0, 0, 0, 0);      // restore count 2 from immediate
    step("R2", 1, 6, 1, 0, 0, 0, 0, 0, 0, 0);      // unused code: no change
    step("R2", 1, 0, 16'h00F0, 16'h00F7, 0, 0, 0, 0, 0, 0); // pointer 7
  endtask

  task automatic t_range();
    step("R3", 1, 0, 8, 0, 0, 0, 0, 0, 0, 0);      // pointer 8 rejected
    step("R3", 1, 4, 8, 0, 0, 0, 0, 0, 0, 0);      // clean 8 accepted
    step("R3", 1, 4, 9, 0, 0, 0, 0, 0, 0, 0);      // clean 9 rejected
    step("R3", 1, 3, 16'h0107, 0, 0, 0, 0, 0, 0, 0); // high bits rejected
    step("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);      // pulse clears
  endtask

  task automatic t_events();
    step("R4", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);      // save: restore count drained
    step("R2", 1, 3, 2, 0, 0, 0, 0, 0, 0, 0);      // other-context 2
    step("R5", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);      // restore: other-context drained, clean saturated
    step("R4", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);      // save at the top: rejected
    step("R2", 1, 4, 3, 0, 0, 0, 0, 0, 0, 0);      // clean 3
    step("R5", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);      // other-context drained to 0
    step("R5", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);      // save count drained, clean up
    step("R4", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);      // save: restore count drained
  endtask

  task automatic t_underflow();
    step("R6", 1, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);      // restore count would go negative
    step("R6", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);      // save count would go negative
    step("R6", 1, 2, 7, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 1, 1, 3, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);      // restore count would exceed top
  endtask

  task automatic t_write_wins();
    step("R7", 1, 2, 4, 0, 0, 0, 1, 0, 1, 2);      // write beats event and trap return
    step("R7", 1, 3, 1, 0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_both_events();
    step("R8", 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
  endtask

  task automatic t_trap();
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1, 5);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1, 9);      // out of range: pointer kept
    step("R9", 1, 1, 2, 0, 0, 0, 0, 0, 1, 1);      // write wins over trap return
    step("R9", 0, 0, 0, 0, 0, 0, 0, 1, 1, 0);      // trap return and event together
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    t_reset();
    t_write();
    t_range();
    t_events();
    t_underflow();
    t_write_wins();
    t_both_events();
    t_trap();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule